// File: doc/BRIEF.md
# Phase-Clock Synchronized Peripheral Bus Cycle Engine

This block carries out one read or write cycle at a time on a slow peripheral bus. The bus is timed by an external phase clock. That phase clock is asynchronous to the system clock, so the engine passes it through a synchronizer chain and then steps its own sequencing on the synchronized level.

A request holds the following fields:
- a 16-pin address-plus-data word;
- a per-pin output-enable mask;
- two 3-bit control groups: the first is driven for the bus cycle and the second is driven after it, usually to deselect;
- a read flag;
- an optional delay counted in whole phase-clock periods.

Once any delay has run out, the engine waits for the phase clock to be low and lets a settle time pass. It then drives the first control group and the pin word, and it applies the output-enable mask one clock later. The engine then waits for the phase clock to go high and lets a second settle time pass. At that point it samples the read bus if the cycle is a read, and it drives the second control group. The engine reports completion on the next low phase.

Two short operations are also available. A pause runs a fixed control sequence and leaves the pins alone. A clear-bus operation makes every pin an output driving zero, and it finishes at once without waiting for the phase clock.

Top module: `phi_bus_engine`

## Requirements
- R1: After reset the block shows `busy`=0, `done`=0, `ctl_out`=3'b111, `bus_out`=0, `bus_oe`=0 and `rd_data`=0.
- R2: A request is taken on a clock edge where `req_valid`=1 and `busy`=0. From the next cycle `busy` stays 1 until `done` pulses. A request presented while `busy`=1 is dropped without effect, and one presented in the same cycle as `done` is taken.
- R3: The delay only counts when `req_op` is 2'b00 or 2'b11 and `req_delay_en`=1. It then waits `req_delay`+1 phase-clock periods, each one a high level followed by a low level, before control sequencing starts. When the request is issued during a high phase, completion comes after `req_delay`+2 falling edges of the phase clock, or after 2 falling edges with no delay.
- R4: `ctl_out` takes the first control group SETTLE_LO clocks after the synchronized phase clock is seen low, and it holds that value through the following rising edge. `ctl_out` takes the second group SETTLE_HI clocks after the high level is seen, and it keeps that group after completion.
- R5: `done` is a one-clock pulse. `busy` falls on the same edge that `done` rises.
- R6: A cycle with `req_read`=1 loads `bus_in` into `rd_data` on the edge where the second control group is driven. A write leaves `rd_data` unchanged.
- R7: `bus_out` takes `req_word` on the edge where the first control group is driven, and `bus_oe` takes `req_dir` one clock later.
- R8: For a pause (`req_op`=2'b01), both control groups are 3'b110 whatever the request's control, word, mask, read and delay fields are. `bus_out`, `bus_oe` and `rd_data` do not change. It completes after 2 phase-clock falls when it is issued in a high phase.
- R9: For a clear (`req_op`=2'b10), `bus_out` becomes 0 and `bus_oe` becomes all ones on the acceptance edge. `done` pulses one clock later, whatever the phase clock is doing.
- R10: The phase clock passes through a two-flop synchronizer. For every operation other than clear, `done` is raised only from a low synchronized phase level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi | input | 1 | External phase clock, asynchronous |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00/11 bus cycle, 01 pause, 10 clear |
| req_read | input | 1 | 1 = read cycle |
| req_word | input | 16 | Address-plus-data pin word |
| req_dir | input | 16 | Per-pin output enable, 1 = drive |
| req_ctl_a | input | 3 | Control group driven for the cycle |
| req_ctl_b | input | 3 | Control group driven after the cycle |
| req_delay_en | input | 1 | Enable the phase-period delay |
| req_delay | input | 16 | Delay count, waits count+1 periods |
| bus_in | input | 8 | Read data bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last sampled read byte |
| bus_out | output | 16 | Pin drive values |
| bus_oe | output | 16 | Pin output enables |
| ctl_out | output | 3 | Control lines |

## Verification
Completion of one operation and acceptance of the next can land in the same clock. `busy` drops on the edge that raises `done`, so a request held on `req_valid` is taken during the `done` cycle. The bench holds a pause request high across a completion. It then judges that `busy` is set again one clock after `done`, and that a second completion follows.

A second collision also matters: a request that arrives while an operation is still running. The bench strobes a clear request in the middle of a delayed cycle. It judges that the pins, the control lines and the completion count show only the first operation.

// File: rtl/phi_bus_pkg.sv
package phi_bus_pkg;

  localparam logic [1:0] OPC_CYCLE = 2'b00;
  localparam logic [1:0] OPC_PAUSE = 2'b01;
  localparam logic [1:0] OPC_CLEAR = 2'b10;

  localparam logic [2:0] PAUSE_CTL = 3'b110;

  typedef enum logic [1:0] {
    TM_IDLE,
    TM_WAIT_HI,
    TM_WAIT_LO
  } tm_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT_LO,
    SQ_SET_LO,
    SQ_WAIT_HI,
    SQ_SET_HI,
    SQ_WAIT_END
  } sq_state_e;

  function automatic logic op_is_clear(input logic [1:0] op);
    return op == OPC_CLEAR;
  endfunction

  function automatic logic op_is_pause(input logic [1:0] op);
    return op == OPC_PAUSE;
  endfunction

  // A delay only applies to bus cycles (codes 00 and 11).
  function automatic logic op_uses_timer(input logic [1:0] op, input logic en);
    return en && !op_is_clear(op) && !op_is_pause(op);
  endfunction

  // Number of phase periods the timer waits for a given count.
  function automatic int unsigned wait_periods(input int unsigned count);
    return count + 1;
  endfunction

endpackage

// File: rtl/phi_sync.sv
module phi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_in,
  output logic phi_lvl
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], phi_in};
  end

  assign phi_lvl = chain[STAGES-1];

endmodule

// File: rtl/phi_delay_timer.sv
module phi_delay_timer
  import phi_bus_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] count,
  input  logic             phi_lvl,
  output logic             fire
);

  tm_state_e        st;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TM_IDLE;
      left <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      case (st)
        TM_IDLE: begin
          if (go) begin
            left <= count;
            st   <= TM_WAIT_HI;
          end
        end
        TM_WAIT_HI: begin
          if (phi_lvl) st <= TM_WAIT_LO;
        end
        TM_WAIT_LO: begin
          if (!phi_lvl) begin
            if (left == '0) begin
              fire <= 1'b1;
              st   <= TM_IDLE;
            end else begin
              left <= left - CNT_W'(1);
              st   <= TM_WAIT_HI;
            end
          end
        end
        default: st <= TM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phi_ctl_sequencer.sv
module phi_ctl_sequencer
  import phi_bus_pkg::*;
#(
  parameter int CTL_W     = 3,
  parameter int RD_W      = 8,
  parameter int SETTLE_LO = 26,
  parameter int SETTLE_HI = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             phi_lvl,
  input  logic [CTL_W-1:0] ctl_a,
  input  logic [CTL_W-1:0] ctl_b,
  input  logic             is_read,
  input  logic [RD_W-1:0]  bus_in,
  output logic [CTL_W-1:0] ctl_out,
  output logic [RD_W-1:0]  rd_data,
  output logic             drive_evt,
  output logic             sample_evt,
  output logic             end_evt
);

  localparam int SET_MAX = (SETTLE_LO > SETTLE_HI) ? SETTLE_LO : SETTLE_HI;
  localparam int SET_W   = $clog2(SET_MAX + 1);
  localparam logic [SET_W-1:0] LO_LAST = SET_W'(SETTLE_LO - 1);
  localparam logic [SET_W-1:0] HI_LAST = SET_W'(SETTLE_HI - 1);

  sq_state_e        st;
  logic [SET_W-1:0] cnt;
  logic             lo_hit;
  logic             hi_hit;

  assign lo_hit     = (st == SQ_SET_LO) && (cnt == LO_LAST);
  assign hi_hit     = (st == SQ_SET_HI) && (cnt == HI_LAST);
  assign drive_evt  = lo_hit;
  assign sample_evt = hi_hit && is_read;
  assign end_evt    = (st == SQ_WAIT_END) && !phi_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      ctl_out <= '1;
      rd_data <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start) st <= SQ_WAIT_LO;
        end
        SQ_WAIT_LO: begin
          if (!phi_lvl) begin
            cnt <= '0;
            st  <= SQ_SET_LO;
          end
        end
        SQ_SET_LO: begin
          if (lo_hit) begin
            ctl_out <= ctl_a;
            st      <= SQ_WAIT_HI;
          end else begin
            cnt <= cnt + SET_W'(1);
          end
        end
        SQ_WAIT_HI: begin
          if (phi_lvl) begin
            cnt <= '0;
            st  <= SQ_SET_HI;
          end
        end
        SQ_SET_HI: begin
          if (hi_hit) begin
            if (is_read) rd_data <= bus_in;
            ctl_out <= ctl_b;
            st      <= SQ_WAIT_END;
          end else begin
            cnt <= cnt + SET_W'(1);
          end
        end
        SQ_WAIT_END: begin
          if (!phi_lvl) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phi_data_stage.sv
module phi_data_stage #(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_go,
  input  logic             clear_go,
  input  logic [PIN_W-1:0] word,
  input  logic [PIN_W-1:0] dir,
  output logic [PIN_W-1:0] bus_out,
  output logic [PIN_W-1:0] bus_oe
);

  logic dir_pend;

  // Values go out first, the direction mask follows one clock later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out  <= '0;
      bus_oe   <= '0;
      dir_pend <= 1'b0;
    end else if (clear_go) begin
      bus_out  <= '0;
      bus_oe   <= '1;
      dir_pend <= 1'b0;
    end else if (load_go) begin
      bus_out  <= word;
      dir_pend <= 1'b1;
    end else if (dir_pend) begin
      bus_oe   <= dir;
      dir_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/phi_bus_engine.sv
module phi_bus_engine
  import phi_bus_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int CTL_W       = 3,
  parameter int RD_W        = 8,
  parameter int DELAY_W     = 16,
  parameter int SETTLE_LO   = 26,
  parameter int SETTLE_HI   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phi,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic               req_read,
  input  logic [PIN_W-1:0]   req_word,
  input  logic [PIN_W-1:0]   req_dir,
  input  logic [CTL_W-1:0]   req_ctl_a,
  input  logic [CTL_W-1:0]   req_ctl_b,
  input  logic               req_delay_en,
  input  logic [DELAY_W-1:0] req_delay,
  input  logic [RD_W-1:0]    bus_in,
  output logic               busy,
  output logic               done,
  output logic [RD_W-1:0]    rd_data,
  output logic [PIN_W-1:0]   bus_out,
  output logic [PIN_W-1:0]   bus_oe,
  output logic [CTL_W-1:0]   ctl_out
);

  localparam logic [CTL_W-1:0] PAUSE_GRP = CTL_W'(PAUSE_CTL);

  // Named internal events
  logic             phi_lvl;
  logic             accept;
  logic             timer_go;
  logic             timer_fire;
  logic             seq_start;
  logic             clear_go;
  logic             clear_evt;
  logic             load_go;
  logic             seq_drive_evt;
  logic             seq_sample_evt;
  logic             seq_end_evt;
  logic             cur_pause;
  logic             cur_clear;

  // Latched request
  logic [1:0]       op_q;
  logic             read_q;
  logic [PIN_W-1:0] word_q;
  logic [PIN_W-1:0] dir_q;
  logic [CTL_W-1:0] ctl_a_q;
  logic [CTL_W-1:0] ctl_b_q;

  assign accept    = req_valid && !busy;
  assign timer_go  = accept && op_uses_timer(req_op, req_delay_en);
  assign clear_go  = accept && op_is_clear(req_op);
  assign seq_start = (accept && !op_is_clear(req_op) && !timer_go) || timer_fire;
  assign cur_pause = op_is_pause(op_q);
  assign cur_clear = op_is_clear(op_q);
  assign clear_evt = busy && cur_clear;
  assign load_go   = seq_drive_evt && !cur_pause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OPC_CYCLE;
      read_q  <= 1'b0;
      word_q  <= '0;
      dir_q   <= '0;
      ctl_a_q <= '1;
      ctl_b_q <= '1;
    end else if (accept) begin
      op_q    <= req_op;
      read_q  <= req_read && !op_is_pause(req_op);
      word_q  <= req_word;
      dir_q   <= req_dir;
      ctl_a_q <= op_is_pause(req_op) ? PAUSE_GRP : req_ctl_a;
      ctl_b_q <= op_is_pause(req_op) ? PAUSE_GRP : req_ctl_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= seq_end_evt || clear_evt;
      if (accept)                         busy <= 1'b1;
      else if (seq_end_evt || clear_evt)  busy <= 1'b0;
    end
  end

  phi_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi_in  (phi),
    .phi_lvl (phi_lvl)
  );

  phi_delay_timer #(
    .CNT_W (DELAY_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (timer_go),
    .count   (req_delay),
    .phi_lvl (phi_lvl),
    .fire    (timer_fire)
  );

  phi_ctl_sequencer #(
    .CTL_W     (CTL_W),
    .RD_W      (RD_W),
    .SETTLE_LO (SETTLE_LO),
    .SETTLE_HI (SETTLE_HI)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (seq_start),
    .phi_lvl    (phi_lvl),
    .ctl_a      (ctl_a_q),
    .ctl_b      (ctl_b_q),
    .is_read    (read_q),
    .bus_in     (bus_in),
    .ctl_out    (ctl_out),
    .rd_data    (rd_data),
    .drive_evt  (seq_drive_evt),
    .sample_evt (seq_sample_evt),
    .end_evt    (seq_end_evt)
  );

  phi_data_stage #(
    .PIN_W (PIN_W)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_go  (load_go),
    .clear_go (clear_go),
    .word     (word_q),
    .dir      (dir_q),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );

endmodule

// File: rtl/phi_bus_engine_chk.sv
module phi_bus_engine_chk #(
  parameter int PIN_W = 16,
  parameter int CTL_W = 3,
  parameter int RD_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [RD_W-1:0]  rd_data,
  input logic [PIN_W-1:0] bus_out,
  input logic [PIN_W-1:0] bus_oe,
  input logic [CTL_W-1:0] ctl_out,
  input logic             phi_lvl,
  input logic             timer_fire,
  input logic             sample_evt,
  input logic             cur_pause,
  input logic             cur_clear
);

  assert_busy_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_fire_from_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_fire |-> !$past(phi_lvl));

  assert_ctl_only_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_out) |-> $past(busy));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_fall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_rd_only_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(sample_evt));

  assert_pause_keeps_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_pause) |-> ($stable(bus_out) && $stable(bus_oe)));

  assert_clear_quick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_clear) |=> done);

  assert_done_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cur_clear) |-> !$past(phi_lvl));

endmodule

bind phi_bus_engine phi_bus_engine_chk #(
  .PIN_W (PIN_W),
  .CTL_W (CTL_W),
  .RD_W  (RD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .rd_data    (rd_data),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .ctl_out    (ctl_out),
  .phi_lvl    (phi_lvl),
  .timer_fire (timer_fire),
  .sample_evt (seq_sample_evt),
  .cur_pause  (cur_pause),
  .cur_clear  (cur_clear)
);

// File: tb/test_phi_bus_engine.sv
`timescale 1ns/1ps
module test_phi_bus_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic        req_read = 1'b0;
  logic [15:0] req_word = '0;
  logic [15:0] req_dir = '0;
  logic [2:0]  req_ctl_a = '0;
  logic [2:0]  req_ctl_b = '0;
  logic        req_delay_en = 1'b0;
  logic [15:0] req_delay = '0;
  logic [7:0]  bus_in = '0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [15:0] bus_out, bus_oe;
  logic [2:0]  ctl_out;

  int checks = 0;
  int errors = 0;
  int falls = 0;
  bit counting = 1'b0;
  logic [2:0]  rise_ctl;
  logic [15:0] rise_bus;
  logic [15:0] exp_bus = '0;
  logic [15:0] exp_oe = '0;
  logic [7:0]  exp_rd = '0;

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #240 phi = ~phi;
  end
  always @(negedge phi) if (counting) falls++;
  always @(posedge phi) begin
    rise_ctl = ctl_out;
    rise_bus = bus_out;
  end

  phi_bus_engine i_phi_bus_engine (
    .clk(clk), .rst_n(rst_n), .phi(phi), .req_valid(req_valid), .req_op(req_op),
    .req_read(req_read), .req_word(req_word), .req_dir(req_dir),
    .req_ctl_a(req_ctl_a), .req_ctl_b(req_ctl_b), .req_delay_en(req_delay_en),
    .req_delay(req_delay), .bus_in(bus_in), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_out(bus_out), .bus_oe(bus_oe), .ctl_out(ctl_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Waits for done at negedges; inject=1 strobes a clear mid-way.
  task automatic wait_done(input bit inject, output bit ok);
    int n = 0;
    ok = 1'b0;
    while (n < 20000) begin
      @(negedge clk);
      if (inject && n == 100) begin req_op = 2'b10; req_valid = 1'b1; end
      if (inject && n == 101) req_valid = 1'b0;
      if (done) begin ok = 1'b1; break; end
      n++;
    end
    if (!ok) begin
      errors++;
      $display("FAIL watchdog no done");
    end
  endtask

  task automatic run_req(input logic [1:0] op, input bit rd, input logic [15:0] w,
                         input logic [15:0] d, input logic [2:0] a, input logic [2:0] b,
                         input bit en, input logic [15:0] dl, input logic [7:0] din,
                         input bit inject, output bit ok);
    @(posedge phi);
    repeat (10) @(negedge clk);
    req_op = op; req_read = rd; req_word = w; req_dir = d; req_ctl_a = a;
    req_ctl_b = b; req_delay_en = en; req_delay = dl; bus_in = din;
    falls = 0; counting = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(inject, ok);
    counting = 1'b0;
  endtask

  initial begin
    bit ok;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(ctl_out == 3'b111, "R1 ctl_out", ctl_out, 3'b111);
    chk(bus_out == 0 && bus_oe == 0, "R1 pins", {bus_out, bus_oe}, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);

    // Sweep of bus cycles: delay on/off, count 0..3, read/write
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w = 16'hC35A ^ 16'(i * 4951);
      logic [15:0] dm = 16'hF0F0 ^ 16'(i * 273);
      logic [2:0] a = 3'(i);
      logic [2:0] b = 3'(7 - i);
      logic [7:0] din = 8'(60 + i * 17);
      bit en = i[0];
      logic [15:0] dl = 16'(i[2:1]);
      bit rd = i[3];
      int exp_falls = en ? int'(dl) + 2 : 2;
      run_req((i % 5 == 4) ? 2'b11 : 2'b00, rd, w, dm, a, b, en, dl, din, 1'b0, ok);
      if (ok) begin
        exp_bus = w; exp_oe = dm;
        if (rd) exp_rd = din;
        chk(falls == exp_falls, "R3 phase falls", falls, exp_falls);
        chk(rise_ctl == a, "R4 first group", rise_ctl, a);
        chk(ctl_out == b, "R4 second group", ctl_out, b);
        chk(rise_bus == w, "R7 pin word", rise_bus, w);
        chk(bus_oe == dm, "R7 direction", bus_oe, dm);
        chk(rd_data == exp_rd, "R6 read data", rd_data, exp_rd);
        chk(busy == 0, "R5 busy low at done", busy, 0);
        chk(phi == 0, "R10 done in low phase", phi, 0);
      end
      @(negedge clk);
      chk(done == 0, "R5 done one pulse", done, 0);
    end

    // Pause ignores fields
    run_req(2'b01, 1'b1, 16'hDEAD, 16'h1234, 3'b000, 3'b001, 1'b1, 16'd3, 8'h77, 1'b0, ok);
    if (ok) begin
      chk(falls == 2, "R8 pause falls", falls, 2);
      chk(rise_ctl == 3'b110, "R8 pause first group", rise_ctl, 3'b110);
      chk(ctl_out == 3'b110, "R8 pause second group", ctl_out, 3'b110);
      chk(bus_out == exp_bus && bus_oe == exp_oe, "R8 pins unchanged", {bus_out, bus_oe}, {exp_bus, exp_oe});
      chk(rd_data == exp_rd, "R8 rd unchanged", rd_data, exp_rd);
    end

    // Clear
    @(negedge clk);
    req_op = 2'b10; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_out == 16'h0000, "R9 clear values", bus_out, 0);
    chk(bus_oe == 16'hFFFF, "R9 clear enables", bus_oe, 16'hFFFF);
    chk(done == 0, "R9 no early done", done, 0);
    @(negedge clk);
    chk(done == 1 && busy == 0, "R9 done next clock", {done, busy}, 2'b10);
    exp_bus = 0; exp_oe = 16'hFFFF;

    // Busy rejection: clear strobed mid-cycle is dropped
    run_req(2'b00, 1'b0, 16'h5AA5, 16'h0F0F, 3'b010, 3'b101, 1'b1, 16'd1, 8'h00, 1'b1, ok);
    if (ok) begin
      chk(bus_out == 16'h5AA5, "R2 reject keeps word", bus_out, 16'h5AA5);
      chk(bus_oe == 16'h0F0F, "R2 reject keeps mask", bus_oe, 16'h0F0F);
      chk(ctl_out == 3'b101, "R2 reject keeps ctl", ctl_out, 3'b101);
      begin
        bit extra = 1'b0;
        repeat (600) begin
          @(negedge clk);
          if (done || busy) extra = 1'b1;
        end
        chk(!extra, "R2 no extra operation", extra, 0);
      end
    end

    // Back-to-back: request held across done is taken in the done cycle
    @(posedge phi);
    repeat (10) @(negedge clk);
    req_op = 2'b01; req_valid = 1'b1;
    wait_done(1'b0, ok);
    if (ok) begin
      @(negedge clk);
      chk(busy == 1 && done == 0, "R2 accept in done cycle", {busy, done}, 2'b10);
      req_valid = 1'b0;
      wait_done(1'b0, ok);
      if (ok) chk(ctl_out == 3'b110, "R8 second pause ctl", ctl_out, 3'b110);
    end

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule